// File: doc/BRIEF.md
# Parallel Bus Master Port Controller

This block lets a host drive an external peripheral over an 8-bit parallel bus. The host programs a configuration word and a bus address, then starts a transfer by writing or reading the data register. The block then runs the bus sequence on its own: it asserts chip select and byte enable, drives the address and, for writes, the data byte, and waits out a programmable setup period. It then pulses the strobe for a programmable width and holds for a programmable period before it releases the bus.

Two strobe styles are offered. One uses separate read and write strobes. The other uses a direction line together with a single enable strobe. A 16-bit data-register access is split into two byte transfers, low byte first. The address can stay fixed, step up or step down after every byte. A busy output covers the whole access, and an optional one-cycle interrupt pulse marks its end.

Top module: `pbus_master`

## Requirements
- R1: After reset the configuration word reads 0, the address is 0, and busy, irq, chip select, byte enable, all strobes and the data output enable are 0.
- R2: busy is 1 for exactly the cycles of a transfer. Chip select and byte enable are 1 in exactly those cycles.
- R3: With a nonzero strobe wait W (cfg[3:0]), setup S (cfg[5:4]) and hold H (cfg[7:6]), each byte takes S+1 cycles before the strobe, W+1 strobe cycles and H+1 cycles after it, all inside chip select. Write data is driven from the first cycle of the byte.
- R4: With W = 0, each byte is a single strobe cycle and S and H have no effect.
- R5: Style cfg[14:13] = 2 pulses bus_rd for reads and bus_wr for writes, and leaves bus_en at 0. Style 3 pulses bus_en and holds bus_dir at 1 for writes and 0 for reads, and leaves bus_rd and bus_wr at 0. With styles 0 and 1, data-register accesses start nothing.
- R6: With cfg[8] = 1, one access makes two byte transfers, low byte first. With cfg[8] = 0 it makes one. Read bytes are sampled on the edge that ends the strobe. rd_data[7:0] holds the first byte and rd_data[15:8] the second, or 0 in 8-bit mode.
- R7: The step mode cfg[10:9] changes the address after every byte transfer: 1 adds 1, 2 subtracts 1, and 0 or 3 leaves it unchanged. The result wraps modulo 2^AW.
- R8: With irq mode cfg[12:11] = 1, irq is 1 for exactly one cycle, the first idle cycle after an access. Modes 0, 2 and 3 never raise irq.
- R9: Data, configuration and address writes presented while busy is 1 are ignored.
- R10: The configuration word reads back as written, with bit 15 always 0. A data write takes priority when dat_wr and dat_rd are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock; every wait unit is one period |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write the configuration word |
| cfg_wdata | input | 16 | Configuration value |
| cfg_rdata | output | 16 | Current configuration |
| addr_wr | input | 1 | Load the bus address |
| addr_wdata | input | AW | Address value |
| addr_q | output | AW | Current address |
| dat_wr | input | 1 | Start a write of dat_wdata |
| dat_wdata | input | 16 | Write data |
| dat_rd | input | 1 | Start a read |
| rd_data | output | 16 | Data from the last read |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | End-of-access pulse |
| bus_cs | output | 1 | Chip select |
| bus_be | output | 1 | Byte enable |
| bus_rd | output | 1 | Read strobe (style 2) |
| bus_wr | output | 1 | Write strobe (style 2) |
| bus_dir | output | 1 | Direction, 1 = write (style 3) |
| bus_en | output | 1 | Enable strobe (style 3) |
| bus_addr | output | AW | Bus address |
| bus_dout | output | 8 | Data byte driven out |
| bus_doe | output | 1 | Output enable for bus_dout |
| bus_din | input | 8 | Data byte from the bus |

## Verification
The bench builds the block with AW = 4. An increment past 15 and a decrement below 0 therefore wrap within a single access. The bench's peripheral model returns a byte derived from the bus address, so one read shows both the byte order and the step applied between the two bytes. The vectors include the largest strobe and setup codes alongside the zero-strobe override, so both extremes of per-byte length are measured.

// File: rtl/pbus_master.sv
module pbus_master #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   cfg_rdata,
  input  logic          addr_wr,
  input  logic [AW-1:0] addr_wdata,
  output logic [AW-1:0] addr_q,
  input  logic          dat_wr,
  input  logic [15:0]   dat_wdata,
  input  logic          dat_rd,
  output logic [15:0]   rd_data,
  output logic          busy,
  output logic          irq,
  output logic          bus_cs,
  output logic          bus_be,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_dir,
  output logic          bus_en,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_dout,
  output logic          bus_doe,
  input  logic [7:0]    bus_din
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {IDLE, SETUP, STRB, HOLD} st_t;

  st_t         st, first_st;
  logic [15:0] cfg_q;
  logic [3:0]  cnt, first_cnt;
  logic        hi, wr_op;
  logic [15:0] wbuf;
  logic [AW-1:0] addr_nx;

  wire [3:0] sw    = cfg_q[3:0];
  wire [1:0] su    = cfg_q[5:4];
  wire [1:0] ho    = cfg_q[7:6];
  wire       wide  = cfg_q[8];
  wire [1:0] step  = cfg_q[10:9];
  wire [1:0] irqm  = cfg_q[12:11];
  wire [1:0] style = cfg_q[14:13];

  assign busy      = (st != IDLE);
  assign cfg_rdata = cfg_q;

  wire start    = !busy && style[1] && (dat_wr || dat_rd);
  wire strobe   = (st == STRB);
  wire byte_end = (cnt == 4'd0) && ((strobe && sw == 4'd0) || st == HOLD);
  wire last     = byte_end && !(wide && !hi);

  assign first_st  = (sw == 4'd0) ? STRB : SETUP;
  assign first_cnt = (sw == 4'd0) ? 4'd0 : {2'b00, su};

  always_comb begin
    case (step)
      2'd1:    addr_nx = addr_q + ONE;
      2'd2:    addr_nx = addr_q - ONE;
      default: addr_nx = addr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      cfg_q   <= '0;
      addr_q  <= '0;
      cnt     <= '0;
      hi      <= 1'b0;
      wr_op   <= 1'b0;
      wbuf    <= '0;
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (!busy && cfg_wr)  cfg_q  <= cfg_wdata & 16'h7FFF;
      if (!busy && addr_wr) addr_q <= addr_wdata;
      case (st)
        IDLE: if (start) begin
          st    <= first_st;
          cnt   <= first_cnt;
          hi    <= 1'b0;
          wr_op <= dat_wr;
          wbuf  <= dat_wdata;
        end
        SETUP: if (cnt == 4'd0) begin
          st  <= STRB;
          cnt <= sw;
        end else cnt <= cnt - 4'd1;
        STRB: if (cnt == 4'd0) begin
          if (!wr_op) begin
            if (hi) rd_data[15:8] <= bus_din;
            else    rd_data       <= {8'h00, bus_din};
          end
          if (sw != 4'd0) begin
            st  <= HOLD;
            cnt <= {2'b00, ho};
          end
        end else cnt <= cnt - 4'd1;
        HOLD: if (cnt != 4'd0) cnt <= cnt - 4'd1;
        default: st <= IDLE;
      endcase
      if (byte_end) begin
        addr_q <= addr_nx;
        if (last) begin
          st  <= IDLE;
          irq <= (irqm == 2'd1);
        end else begin
          hi  <= 1'b1;
          st  <= first_st;
          cnt <= first_cnt;
        end
      end
    end
  end

  assign bus_cs   = busy;
  assign bus_be   = busy;
  assign bus_addr = addr_q;
  assign bus_rd   = strobe && !style[0] && !wr_op;
  assign bus_wr   = strobe && !style[0] && wr_op;
  assign bus_en   = strobe && style[0];
  assign bus_dir  = busy && style[0] && wr_op;
  assign bus_doe  = busy && wr_op;
  assign bus_dout = hi ? wbuf[15:8] : wbuf[7:0];

endmodule

// File: rtl/pbus_master_chk.sv
module pbus_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        irq,
  input logic        bus_cs,
  input logic        bus_be,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic        bus_en,
  input logic        bus_doe,
  input logic [15:0] cfg_rdata
);

  // R2
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bus_cs && bus_be));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  // R5
  style_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> !bus_en);

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R8
  irq_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && $past(busy)));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_rdata));

  // R4
  zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_rdata[3:0] == 4'd0) |-> (bus_rd || bus_wr || bus_en));

  // R6
  doe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> bus_cs);

endmodule

bind pbus_master pbus_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .bus_cs(bus_cs),
  .bus_be(bus_be), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_en(bus_en),
  .bus_doe(bus_doe), .cfg_rdata(cfg_rdata)
);

// File: tb/pbus_master_tb.sv
`timescale 1ns/1ps
module pbus_master_tb;
  localparam int AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, addr_wr = 0, dat_wr = 0, dat_rd = 0;
  logic [15:0] cfg_wdata = 0, dat_wdata = 0;
  logic [AW-1:0] addr_wdata = 0;
  logic [15:0] cfg_rdata, rd_data;
  logic [AW-1:0] addr_q, bus_addr;
  logic busy, irq, bus_cs, bus_be, bus_rd, bus_wr, bus_dir, bus_en, bus_doe;
  logic [7:0] bus_dout, bus_din;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;
  assign bus_din = {4'hC, bus_addr};

  pbus_master #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
    .addr_q(addr_q), .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd),
    .rd_data(rd_data), .busy(busy), .irq(irq), .bus_cs(bus_cs), .bus_be(bus_be),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_dir(bus_dir), .bus_en(bus_en),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
  );

  typedef struct packed {
    logic [15:0] cfg;
    logic [3:0]  a;
    logic [15:0] wd;
    logic        rd;
    logic [7:0]  len;
    logic [7:0]  pre;
    logic [7:0]  strb;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'h48F0, 4'd5,  16'h00A7, 1'b0, 8'd1,  8'd0, 8'd1},
    '{16'h4292, 4'd15, 16'h005C, 1'b0, 8'd8,  8'd2, 8'd3},
    '{16'h6D01, 4'd0,  16'h0000, 1'b1, 8'd8,  8'd1, 8'd4},
    '{16'h733F, 4'd7,  16'hBE3D, 1'b0, 8'd42, 8'd4, 8'd32},
    '{16'h4B00, 4'd3,  16'h0000, 1'b1, 8'd2,  8'd0, 8'd2},
    '{16'h46E3, 4'd9,  16'h0000, 1'b1, 8'd11, 8'd3, 8'd4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put_cfg(input logic [15:0] v);
    @(negedge clk) begin cfg_wr = 1; cfg_wdata = v; end
    @(negedge clk) cfg_wr = 0;
  endtask

  task automatic put_addr(input logic [3:0] v);
    @(negedge clk) begin addr_wr = 1; addr_wdata = v; end
    @(negedge clk) addr_wr = 0;
  endtask

  function automatic logic [3:0] stepped(input logic [3:0] a, input logic [1:0] m);
    if (m == 2'd1) return a + 4'd1;
    if (m == 2'd2) return a - 4'd1;
    return a;
  endfunction

  task automatic run_xfer(input vec_t v, input bit poke, input string tag);
    int len = 0, pre = 0, strb = 0, wrong = 0;
    bit seen = 0, s;
    logic [7:0] lo_b = 0, hi_b = 0;
    logic [3:0] a1, a2;
    logic [15:0] exp_rd;
    bit wide = v.cfg[8];
    logic [1:0] stp = v.cfg[10:9];
    logic [1:0] sty = v.cfg[14:13];
    put_cfg(v.cfg);
    put_addr(v.a);
    @(negedge clk) begin
      dat_wdata = v.wd;
      if (v.rd) dat_rd = 1; else dat_wr = 1;
    end
    @(negedge clk) begin dat_rd = 0; dat_wr = 0; end
    while (busy && len < 200) begin
      len++;
      s = bus_rd | bus_wr | bus_en;
      if (!bus_cs || !bus_be) wrong++;
      if (s) begin
        if (!seen) lo_b = bus_dout;
        seen = 1; hi_b = bus_dout; strb++;
      end else if (!seen) pre++;
      if (sty == 2'd2 && (bus_en || (v.rd ? bus_wr : bus_rd))) wrong++;
      if (sty == 2'd3 && (bus_rd || bus_wr || bus_dir == v.rd)) wrong++;
      if (bus_doe == v.rd) wrong++;
      if (poke && len == 5) begin
        dat_rd = 1; cfg_wr = 1; cfg_wdata = 16'h0000; addr_wr = 1; addr_wdata = 4'hA;
      end
      if (poke && len == 6) begin dat_rd = 0; cfg_wr = 0; addr_wr = 0; end
      @(negedge clk);
    end
    chk({"R2 busy length ", tag}, len, v.len);
    chk({"R2 cs/be inside busy ", tag}, wrong == 0 ? 0 : 1, 0);
    chk({"R3/R4 cycles before strobe ", tag}, pre, v.pre);
    chk({"R3/R4 strobe cycles ", tag}, strb, v.strb);
    chk({"R5 strobe lines ", tag}, wrong, 0);
    a1 = stepped(v.a, stp);
    a2 = wide ? stepped(a1, stp) : a1;
    chk({"R7 address after ", tag}, addr_q, a2);
    chk({"R8 irq ", tag}, irq, v.cfg[12:11] == 2'd1);
    if (v.rd) begin
      exp_rd = wide ? {4'hC, a1, 4'hC, v.a} : {8'h00, 4'hC, v.a};
      chk({"R6 read data ", tag}, rd_data, exp_rd);
    end else begin
      chk({"R6 first byte ", tag}, lo_b, v.wd[7:0]);
      if (wide) chk({"R6 second byte ", tag}, hi_b, v.wd[15:8]);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 busy", busy, 0);
    chk("R1 irq", irq, 0);
    chk("R1 cfg", cfg_rdata, 0);
    chk("R1 addr", addr_q, 0);
    chk("R1 bus lines", {bus_cs, bus_be, bus_rd, bus_wr, bus_en, bus_dir, bus_doe}, 0);

    for (int i = 0; i < 6; i++) run_xfer(VECS[i], 1'b0, $sformatf("vec%0d", i));

    // R10
    put_cfg(16'h46E3);
    chk("R10 cfg readback", cfg_rdata, 16'h46E3);
    put_cfg(16'hFFFF);
    chk("R10 bit 15 zero", cfg_rdata, 16'h7FFF);

    // R5 style 0 starts nothing
    put_cfg(16'h0005);
    @(negedge clk) dat_wr = 1;
    @(negedge clk) dat_wr = 0;
    chk("R5 style 0 busy", busy, 0);
    @(negedge clk);
    chk("R5 style 0 cs", bus_cs, 0);

    // R9 accesses during busy ignored
    run_xfer(VECS[3], 1'b1, "poke");
    chk("R9 cfg kept", cfg_rdata, 16'h733F);
    repeat (3) @(negedge clk);
    chk("R9 no extra transfer", busy, 0);
    chk("R9 address kept", addr_q, 4'd9);

    // R10 write wins over read
    put_cfg(16'h4000);
    put_addr(4'd2);
    @(negedge clk) begin dat_wdata = 16'h0033; dat_wr = 1; dat_rd = 1; end
    @(negedge clk) begin dat_wr = 0; dat_rd = 0; end
    chk("R10 write priority", {bus_wr, bus_rd, bus_dout}, {2'b10, 8'h33});
    repeat (2) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule